// File: doc/BRIEF.md
# Trailing-Load Block Guard

This block keeps a cache block resident until the trailing copy of a redundantly executed thread has read it. The leading thread reads a cached block first. If the cache then replaced or invalidated that block before the trailing thread reached the same load, the two copies would read different data. The output comparison would then report a mismatch that no real fault caused. To prevent this, the guard counts, for each block-aligned address, the leading loads whose trailing twins have not yet retired.

A small fully associative table holds one slot per guarded block. Each slot has a tag, an outstanding-load counter and a deferred-eviction flag. Retiring leading loads fill the table and retiring trailing loads drain it. The cache asks the guard before every replacement or invalidation. The answer comes back in the same cycle:
- If the block has loads outstanding, the request is refused and the slot remembers that an eviction is waiting.
- Once the last trailing load to that block has retired, the guard pulses a release carrying the block address, and the slot becomes free again.

The leading-load port is valid/ready. A load transfers on a cycle where both are high. The guard lowers ready when the load has nowhere to be counted:
- no free slot for a new block,
- the block's counter already at its maximum, or
- the block is being released in that very cycle.

Trailing retirements, eviction requests and releases are plain single-cycle strobes.

Top module: `ld_guard_buf`

## Requirements
- R1: After reset every slot is empty. No release is signalled, every eviction request is granted, and a leading load to any block is accepted.
- R2: Each accepted leading load adds one to the outstanding count of its block, and allocates a slot when the block is not yet tracked. While that count is nonzero, an eviction request for the block is refused.
- R3: An eviction request for a block with no tracked slot is granted combinationally, in the same cycle the request is presented, and changes no state.
- R4: Each trailing retirement removes one from its block's count. When the count reaches zero and no eviction was refused for the block, the slot is freed silently, with no release, and later evictions of the block are granted.
- R5: A refused eviction marks the slot pending, and later refusals leave it pending. In the cycle after the clock edge that brings the count to zero, a one-cycle release is raised. Its address is the block address with the low offset bits zero, and the slot is free afterwards.
- R6: Blocks are matched fully associatively on the address above the offset bits. Addresses that differ only in the offset bits (the low OFF_BITS bits) share one slot and one count.
- R7: When a leading load misses every slot and no slot is free, ready is low. Loads to blocks already tracked are still accepted.
- R8: When a block's count is at its maximum (2^CNT_W - 1), ready is low for loads to that block.
- R9: A leading load to a block during that block's release cycle is held off (ready low). In the next cycle it is accepted into a fresh slot.
- R10: A leading and a trailing load to the same block retiring in the same cycle leave its count unchanged.
- R11: An eviction request in the same cycle as the trailing retirement that empties the block is judged on the count before that retirement. It is refused, and the release follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Leading load retiring |
| ld_ready | output | 1 | Guard can count the leading load |
| ld_addr | input | ADDR_W | Leading load address |
| tr_valid | input | 1 | Trailing load retiring |
| tr_addr | input | ADDR_W | Trailing load address |
| ev_valid | input | 1 | Cache asks to replace or invalidate a block |
| ev_addr | input | ADDR_W | Address of the block to be evicted |
| ev_grant | output | 1 | High: eviction may proceed; low while ev_valid: refused |
| rel_valid | output | 1 | One-cycle pulse: a deferred eviction may now proceed |
| rel_addr | output | ADDR_W | Block-aligned address of the released block |

## Verification
The embedded properties assume the following about the inputs:
- A trailing load only retires against a block that a leading load has already counted. Counters therefore never underflow.
- The leading source honours ready, so no counter wraps.

The stimulus keeps to these rules by construction. Every trailing retirement it issues pairs with an earlier accepted leading load. It offers loads the guard must refuse only as probes, and withdraws them without a transfer. The eviction sweep covers every tag of the reduced configuration against one busy block.

// File: rtl/alb_pkg.sv
package alb_pkg;
  localparam int MAX_SLOTS = 64;

  // isolate the least significant set bit
  function automatic logic [MAX_SLOTS-1:0] lowest_set(input logic [MAX_SLOTS-1:0] v);
    return v & (~v + 1'b1);
  endfunction
endpackage

// File: rtl/alb_pick.sv
module alb_pick #(
  parameter int N = 16
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  import alb_pkg::*;
  logic [MAX_SLOTS-1:0] wide;

  always_comb begin
    wide = lowest_set(MAX_SLOTS'(req));
    gnt  = wide[N-1:0];
    any  = |req;
  end
endmodule

// File: rtl/alb_entry.sv
module alb_entry #(
  parameter int TAG_W = 26,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [TAG_W-1:0] tag_new,
  input  logic             inc,
  input  logic             dec,
  input  logic             mark,
  input  logic             clr,
  output logic [TAG_W-1:0] tag,
  output logic [CNT_W-1:0] cnt,
  output logic             pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag  <= '0;
      cnt  <= '0;
      pend <= 1'b0;
    end else if (alloc) begin
      tag  <= tag_new;
      cnt  <= CNT_W'(1);
      pend <= 1'b0;
    end else begin
      cnt <= cnt + CNT_W'(inc) - CNT_W'(dec);
      if (mark)     pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end

  // R8
  cnt_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec) |-> (cnt != '1));

  // R4
  trl_undr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc) |-> (cnt != '0));

  // R5
  rel_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && !pend));

  // R5
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && cnt != '0) |=> pend);
endmodule

// File: rtl/ld_guard_buf.sv
module ld_guard_buf #(
  parameter int ADDR_W   = 32,
  parameter int OFF_BITS = 6,
  parameter int SLOTS    = 16,
  parameter int CNT_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              tr_valid,
  input  logic [ADDR_W-1:0] tr_addr,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  output logic              ev_grant,
  output logic              rel_valid,
  output logic [ADDR_W-1:0] rel_addr
);
  localparam int TAG_W = ADDR_W - OFF_BITS;

  logic [TAG_W-1:0] ld_tag, tr_tag, ev_tag;
  logic [TAG_W-1:0] s_tag [SLOTS];
  logic [CNT_W-1:0] s_cnt [SLOTS];
  logic [SLOTS-1:0] s_pend, s_used, s_busy, s_full, s_relc;
  logic [SLOTS-1:0] ld_hit, tr_hit, ev_hit;
  logic [SLOTS-1:0] free_gnt, rel_gnt, alloc_v, inc_v, dec_v, mark_v;
  logic             free_any, rel_any, ld_fire, any_hit;
  logic [TAG_W-1:0] rel_tag;

  assign ld_tag = ld_addr[ADDR_W-1:OFF_BITS];
  assign tr_tag = tr_addr[ADDR_W-1:OFF_BITS];
  assign ev_tag = ev_addr[ADDR_W-1:OFF_BITS];

  genvar i;
  generate
    for (i = 0; i < SLOTS; i++) begin : g_slot
      assign s_busy[i] = (s_cnt[i] != '0);
      assign s_used[i] = s_busy[i] | s_pend[i];
      assign s_full[i] = (s_cnt[i] == '1);
      assign s_relc[i] = s_pend[i] & ~s_busy[i];
      assign ld_hit[i] = s_used[i] && (s_tag[i] == ld_tag);
      assign tr_hit[i] = s_used[i] && (s_tag[i] == tr_tag);
      assign ev_hit[i] = s_used[i] && (s_tag[i] == ev_tag);
      assign inc_v[i]  = ld_fire & ld_hit[i];
      assign alloc_v[i] = ld_fire & ~any_hit & free_gnt[i];
      assign dec_v[i]  = tr_valid & tr_hit[i];
      assign mark_v[i] = ev_valid & ev_hit[i] & s_busy[i];

      alb_entry #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_ent (
        .clk(clk), .rst_n(rst_n), .alloc(alloc_v[i]), .tag_new(ld_tag),
        .inc(inc_v[i]), .dec(dec_v[i]), .mark(mark_v[i]), .clr(rel_gnt[i]),
        .tag(s_tag[i]), .cnt(s_cnt[i]), .pend(s_pend[i]));
    end
  endgenerate

  alb_pick #(.N(SLOTS)) u_free (.req(~s_used), .gnt(free_gnt), .any(free_any));
  alb_pick #(.N(SLOTS)) u_rel  (.req(s_relc),  .gnt(rel_gnt),  .any(rel_any));

  assign any_hit = |ld_hit;

  // stall: counter saturated, block releasing now, or no room for a new block
  always_comb begin
    if (any_hit) ld_ready = ~|(ld_hit & (s_full | s_relc));
    else         ld_ready = free_any;
  end
  assign ld_fire  = ld_valid & ld_ready;
  assign ev_grant = ~|(ev_hit & s_busy);

  always_comb begin
    rel_tag = '0;
    for (int k = 0; k < SLOTS; k++)
      if (rel_gnt[k]) rel_tag = rel_tag | s_tag[k];
  end
  assign rel_valid = rel_any;
  assign rel_addr  = {rel_tag, {OFF_BITS{1'b0}}};

  // R6
  tag_uniq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_hit));

  // R3
  miss_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !(|ev_hit)) |-> ev_grant);

  // R5
  rel_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rel_gnt));
endmodule

// File: tb/sim_ld_guard_buf.sv
`timescale 1ns/100ps
module sim_ld_guard_buf;
  localparam int AW = 16, OB = 4, NS = 4, CW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 0, tr_valid = 0, ev_valid = 0;
  logic [AW-1:0] ld_addr = '0, tr_addr = '0, ev_addr = '0;
  logic ld_ready, ev_grant, rel_valid;
  logic [AW-1:0] rel_addr;
  int runs = 0, fails = 0;

  always #2 clk = ~clk;

  ld_guard_buf #(.ADDR_W(AW), .OFF_BITS(OB), .SLOTS(NS), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
    .tr_valid(tr_valid), .tr_addr(tr_addr), .ev_valid(ev_valid), .ev_addr(ev_addr),
    .ev_grant(ev_grant), .rel_valid(rel_valid), .rel_addr(rel_addr));

  task automatic chk(input logic ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  task automatic lead(input logic [AW-1:0] a, input logic exp, input string r);
    ld_valid = 1; ld_addr = a; #1;
    chk(ld_ready === exp, r, 32'(ld_ready), 32'(exp));
    if (!exp) ld_valid = 0;
    @(posedge clk); #1;
    ld_valid = 0;
  endtask

  task automatic trail(input logic [AW-1:0] a);
    tr_valid = 1; tr_addr = a;
    @(posedge clk); #1;
    tr_valid = 0;
  endtask

  task automatic evict(input logic [AW-1:0] a, input logic exp, input string r);
    ev_valid = 1; ev_addr = a; #1;
    chk(ev_grant === exp, r, 32'(ev_grant), 32'(exp));
    @(posedge clk); #1;
    ev_valid = 0;
  endtask

  task automatic rel(input logic v, input logic [AW-1:0] a, input string r);
    chk(rel_valid === v, r, 32'(rel_valid), 32'(v));
    if (v) chk(rel_addr === a, r, 32'(rel_addr), 32'(a));
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rel(1'b0, '0, "R1");
    evict(16'h1230, 1'b1, "R1");
    lead(16'h4440, 1'b1, "R1");
    trail(16'h4440);

    // R2 R4 R5 R6 : counts 1..3, offsets vary, deferred eviction
    for (int n = 1; n <= 3; n++) begin
      logic [AW-1:0] b;
      b = AW'(n) << 8;
      for (int k = 0; k < n; k++) lead(b | AW'(k * 5), 1'b1, "R2_R6");
      evict(b | 16'h000f, 1'b0, "R2");
      for (int k = 0; k < n - 1; k++) begin
        trail(b | AW'(k));
        rel(1'b0, '0, "R5");
        evict(b, 1'b0, "R5");
      end
      trail(b | 16'h0003);
      rel(1'b1, b, "R5");
      idle();
      rel(1'b0, '0, "R5");
      evict(b, 1'b1, "R5");
      // R4 silent drain
      for (int k = 0; k < n; k++) lead(b, 1'b1, "R4");
      for (int k = 0; k < n; k++) trail(b);
      rel(1'b0, '0, "R4");
      evict(b, 1'b1, "R4");
    end

    // R7 table full
    for (int s = 1; s <= NS; s++) lead(AW'(s) << 12, 1'b1, "R7");
    lead(16'h5000, 1'b0, "R7");
    lead(16'h1008, 1'b1, "R7");
    trail(16'h1000); trail(16'h1000);
    for (int s = 2; s <= NS; s++) trail(AW'(s) << 12);
    lead(16'h5000, 1'b1, "R7");
    trail(16'h5000);

    // R8 counter saturation
    for (int k = 0; k < 3; k++) lead(16'h6000, 1'b1, "R8");
    lead(16'h6004, 1'b0, "R8");
    for (int k = 0; k < 3; k++) trail(16'h6000);
    evict(16'h6000, 1'b1, "R8");

    // R9 load during release cycle
    lead(16'h7000, 1'b1, "R9");
    evict(16'h7000, 1'b0, "R9");
    trail(16'h7000);
    rel(1'b1, 16'h7000, "R9");
    lead(16'h7002, 1'b0, "R9");
    rel(1'b0, '0, "R9");
    lead(16'h7002, 1'b1, "R9");
    evict(16'h7000, 1'b0, "R9");
    trail(16'h7000);
    rel(1'b1, 16'h7000, "R9");
    idle();

    // R10 simultaneous lead and trail
    lead(16'h8000, 1'b1, "R10");
    ld_valid = 1; ld_addr = 16'h8001; tr_valid = 1; tr_addr = 16'h8002; #1;
    chk(ld_ready === 1'b1, "R10", 32'(ld_ready), 32'h1);
    @(posedge clk); #1;
    ld_valid = 0; tr_valid = 0;
    evict(16'h8000, 1'b0, "R10");
    trail(16'h8000);
    rel(1'b1, 16'h8000, "R10");
    idle();

    // R11 evict in the emptying cycle
    lead(16'h9000, 1'b1, "R11");
    tr_valid = 1; tr_addr = 16'h9000; ev_valid = 1; ev_addr = 16'h9007; #1;
    chk(ev_grant === 1'b0, "R11", 32'(ev_grant), 32'h0);
    @(posedge clk); #1;
    tr_valid = 0; ev_valid = 0;
    rel(1'b1, 16'h9000, "R11");
    idle();

    // R3 sweep every tag against one busy block (tag 0x055)
    lead(16'h0550, 1'b1, "R3");
    for (int t = 0; t < 4096; t++) begin
      logic [AW-1:0] a;
      a = {t[11:0], t[3:0]};
      evict(a, (t != 16'h055), "R3");
    end
    trail(16'h0550);
    rel(1'b1, 16'h0550, "R3");
    idle();
    rel(1'b0, '0, "R3");

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule